// File: doc/BRIEF.md
# Low-Power Idle Transmit Sequencer

This block sits between the MAC-facing transmit pins of a 100 Mbps PHY and its code-group encoder. It watches the transmit enable, error and nibble lines together with a link-good flag. From them it tells the encoder which kind of 5-bit code-group to put on the line next: payload data, the idle group, the sleep group, or no signal at all. While the MAC keeps asking for low-power idle, the sequencer walks through a timed sleep phase and then alternates between long silent stretches and short refresh bursts. The refresh bursts keep the far end locked and equalized.

The low-power request is one out-of-band pattern on the transmit pins: enable low, error high, nibble 0001. Dropping the request during sleep, silence or refresh starts a timed wake phase, which sends idles and then returns to the active state. Losing link sends the block straight back to the active state. Every phase length is a cycle count set by a parameter. The defaults assume a 25 MHz clock and the longest allowed silent stretch; simulation can use short values.

Top module: `lpi_tx_seq`

## Requirements
- R1: While reset is asserted, and in the first cycles after it, the sequencer is in the active state: `sel` is 01 (idle) when `tx_en` is 0, and `lp_mode` is 0.
- R2: In the active state, `tx_en`=1 gives `sel`=00 (data). Every other pin pattern that is not the low-power request gives `sel`=01 (idle) and leaves the state active. This includes `tx_er`=1 with `txd` of 0000 or 0010, and `tx_er`=0 with any nibble.
- R3: A low-power request (`tx_en`=0, `tx_er`=1, `txd`=0001) seen in the active state with `link_ok`=1 enters the sleep phase at the next clock edge. Sleep drives `sel`=10 (sleep group) with `lp_mode`=1 for exactly SLEEP_CYC cycles.
- R4: When sleep ends with the request still held, the quiet phase follows. Quiet drives `sel`=11 (line silent) with `lp_mode`=1 for exactly QUIET_CYC cycles.
- R5: When quiet ends with the request held, a refresh phase drives `sel`=10 with `lp_mode`=1 for exactly REFRESH_CYC cycles and then returns to quiet. Every later quiet and refresh phase has the same length as the first.
- R6: Removing the request during sleep, quiet or refresh enters the wake phase at the next edge. Wake drives `sel`=01 with `lp_mode`=0 for exactly WAKE_CYC cycles, after which the sequencer is active.
- R7: `link_ok`=0 returns the sequencer to the active state at the next edge from any state and clears the phase timer. A later request then gets a full-length sleep phase.
- R8: A low-power request has no effect while `link_ok`=0 or while the wake phase runs. Wake always runs to its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| link_ok | input | 1 | Link is established |
| tx_en | input | 1 | MAC transmit enable |
| tx_er | input | 1 | MAC transmit error / out-of-band flag |
| txd | input | 4 | MAC transmit nibble |
| sel | output | 2 | Code-group kind: 00 data, 01 idle, 10 sleep, 11 silent |
| lp_mode | output | 1 | High in sleep, quiet and refresh |

## Verification
`sel` and `lp_mode` are combinational from the registered phase and the present `tx_en`. A change on the pins appears on the outputs in the same cycle only through `tx_en` (data versus idle). Any phase change appears one clock edge after the pins that cause it. Each phase then lasts exactly its parameter's count of cycles. The bench drives inputs on the falling edge and queues one expected value per cycle. A monitor compares those values shortly after the falling edge, so every phase boundary is checked on the exact cycle it is due.

// File: rtl/lpi_tx_pkg.sv
package lpi_tx_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_QUIET   = 3'd2,
    ST_REFRESH = 3'd3,
    ST_WAKE    = 3'd4
  } lpi_state_t;

  typedef enum logic [1:0] {
    SEL_DATA   = 2'b00,
    SEL_IDLE   = 2'b01,
    SEL_SLEEP  = 2'b10,
    SEL_SILENT = 2'b11
  } code_sel_t;
endpackage

// File: rtl/lpi_tx_opdec.sv
module lpi_tx_opdec (
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic       lpi_req,
  output logic       data_req
);
  localparam logic [3:0] LPI_NIBBLE = 4'b0001;

  always_comb begin
    data_req = tx_en;
    lpi_req  = !tx_en && tx_er && (txd == LPI_NIBBLE);
  end
endmodule

// File: rtl/lpi_tx_timer.sv
module lpi_tx_timer #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = run || clear;
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
    done   = run && (cnt_q == limit - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: a phase never runs past its programmed length
  assert_cnt_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear) |-> (cnt_q < limit));
endmodule

// File: rtl/lpi_tx_seq.sv
module lpi_tx_seq #(
  parameter int SLEEP_CYC   = 5250,
  parameter int QUIET_CYC   = 550000,
  parameter int REFRESH_CYC = 5250,
  parameter int WAKE_CYC    = 825
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_ok,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic [1:0] sel,
  output logic       lp_mode
);
  import lpi_tx_pkg::*;

  localparam int MAX_A  = (SLEEP_CYC > REFRESH_CYC) ? SLEEP_CYC : REFRESH_CYC;
  localparam int MAX_B  = (QUIET_CYC > WAKE_CYC) ? QUIET_CYC : WAKE_CYC;
  localparam int MAX_CY = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = $clog2(MAX_CY + 1);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  logic lpi_req, data_req;
  lpi_tx_opdec u_dec (
    .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .lpi_req(lpi_req), .data_req(data_req)
  );

  lpi_state_t    state_q, state_d;
  logic [CW-1:0] limit;
  logic          phase_done, tmr_run, tmr_clear;

  always_comb begin
    case (state_q)
      ST_SLEEP:   limit = CW'(SLEEP_CYC);
      ST_QUIET:   limit = CW'(QUIET_CYC);
      ST_REFRESH: limit = CW'(REFRESH_CYC);
      ST_WAKE:    limit = CW'(WAKE_CYC);
      default:    limit = CW'(1);
    endcase
  end

  lpi_tx_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(srst_n), .run(tmr_run), .clear(tmr_clear),
    .limit(limit), .done(phase_done)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    if (!link_ok) begin
      state_d = ST_ACTIVE;
    end else begin
      case (state_q)
        ST_ACTIVE:  if (lpi_req) state_d = ST_SLEEP;
        ST_SLEEP:   if (!lpi_req) state_d = ST_WAKE;
                    else if (phase_done) state_d = ST_QUIET;
        ST_QUIET:   if (!lpi_req) state_d = ST_WAKE;
                    else if (phase_done) state_d = ST_REFRESH;
        ST_REFRESH: if (!lpi_req) state_d = ST_WAKE;
                    else if (phase_done) state_d = ST_QUIET;
        ST_WAKE:    if (phase_done) state_d = ST_ACTIVE;
        default:    state_d = ST_ACTIVE;
      endcase
    end
    tmr_clear = (state_d != state_q) || (state_q == ST_ACTIVE);
    tmr_run   = (state_q != ST_ACTIVE);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= ST_ACTIVE;
    else         state_q <= state_d;
  end

  // output selection
  always_comb begin
    case (state_q)
      ST_SLEEP, ST_REFRESH: sel = SEL_SLEEP;
      ST_QUIET:             sel = SEL_SILENT;
      ST_WAKE:              sel = SEL_IDLE;
      default:              sel = data_req ? SEL_DATA : SEL_IDLE;
    endcase
    lp_mode = (state_q == ST_SLEEP) || (state_q == ST_QUIET) ||
              (state_q == ST_REFRESH);
  end

  // R7: link loss forces the active state
  assert_link_loss_active_R7: assert property (@(posedge clk) disable iff (!srst_n)
    !link_ok |=> (state_q == ST_ACTIVE));

  // R6: dropping the request in a low-power phase starts wake
  assert_drop_to_wake_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (lp_mode && link_ok && !lpi_req) |=> (state_q == ST_WAKE));

  // R4: quiet is reached only through sleep or refresh
  assert_quiet_entry_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == ST_ACTIVE || state_q == ST_WAKE) |=> (state_q != ST_QUIET));

  // R8: wake is not cut short by a new request
  assert_wake_holds_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == ST_WAKE && link_ok && !phase_done) |=> (state_q == ST_WAKE));

  // R6: wake completes into the active state
  assert_wake_exit_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == ST_WAKE && link_ok && phase_done) |=> (state_q == ST_ACTIVE));
endmodule

// File: tb/lpi_tx_seq_test.sv
module lpi_tx_seq_test;
  localparam int SL = 6, QT = 10, RF = 6, WK = 4;

  logic       clk = 1'b0;
  logic       rst_n, link_ok, tx_en, tx_er;
  logic [3:0] txd;
  logic [1:0] sel;
  logic       lp_mode;

  always #5 clk = ~clk;

  lpi_tx_seq #(.SLEEP_CYC(SL), .QUIET_CYC(QT), .REFRESH_CYC(RF), .WAKE_CYC(WK)) uut (
    .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .tx_en(tx_en),
    .tx_er(tx_er), .txd(txd), .sel(sel), .lp_mode(lp_mode)
  );

  typedef struct {
    logic [1:0] code;
    logic       lp;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, fails = 0;
  bit   finished = 0;

  localparam logic [1:0] D = 2'b00, I = 2'b01, P = 2'b10, S = 2'b11;

  // driver: apply one pattern per cycle for n cycles, queue expectations
  task automatic drive(input int n, input logic en, input logic er, input logic [3:0] d,
                       input logic lk, input logic [1:0] code, input logic lp, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tx_en = en; tx_er = er; txd = d; link_ok = lk;
      exp_q.push_back('{code, lp, tag});
    end
  endtask

  task automatic req(input int n, input logic lk, input logic [1:0] c, input logic lp, input string t);
    drive(n, 1'b0, 1'b1, 4'b0001, lk, c, lp, t);
  endtask

  task automatic idle(input int n, input logic lk, input logic [1:0] c, input logic lp, input string t);
    drive(n, 1'b0, 1'b0, 4'b0000, lk, c, lp, t);
  endtask

  // monitor: compares away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (sel !== e.code || lp_mode !== e.lp) begin
          fails++;
          $display("FAIL %s: sel=%b lp_mode=%b expected sel=%b lp_mode=%b",
                   e.tag, sel, lp_mode, e.code, e.lp);
        end
      end
    end
  end

  initial begin
    #150000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; link_ok = 1'b1; tx_en = 1'b0; tx_er = 1'b0; txd = 4'h0;
    #23;
    checks++;
    if (sel !== I || lp_mode !== 1'b0) begin
      fails++;
      $display("FAIL R1: sel=%b lp_mode=%b expected sel=%b lp_mode=0", sel, lp_mode, I);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(4, 1'b1, I, 1'b0, "R1 after reset");

    // R2: active-state decode
    drive(2, 1'b1, 1'b0, 4'hA, 1'b1, D, 1'b0, "R2 data");
    drive(1, 1'b0, 1'b1, 4'b0000, 1'b1, I, 1'b0, "R2 reserved 0000");
    drive(1, 1'b0, 1'b1, 4'b0010, 1'b1, I, 1'b0, "R2 reserved 0010");
    drive(1, 1'b0, 1'b0, 4'b0001, 1'b1, I, 1'b0, "R2 interframe 0001");
    drive(1, 1'b1, 1'b1, 4'b0001, 1'b1, D, 1'b0, "R2 tx error");
    idle(1, 1'b1, I, 1'b0, "R2 still active");

    // R3/R4/R5: full low-power loop, then drop in quiet (R6)
    req(1, 1'b1, I, 1'b0, "R3 request cycle");
    req(SL, 1'b1, P, 1'b1, "R3 sleep");
    req(QT, 1'b1, S, 1'b1, "R4 quiet");
    req(RF, 1'b1, P, 1'b1, "R5 refresh 1");
    req(QT, 1'b1, S, 1'b1, "R5 quiet 2");
    req(RF, 1'b1, P, 1'b1, "R5 refresh 2");
    req(3, 1'b1, S, 1'b1, "R5 quiet 3");
    idle(1, 1'b1, S, 1'b1, "R6 drop in quiet");
    idle(WK, 1'b1, I, 1'b0, "R6 wake from quiet");
    idle(1, 1'b1, I, 1'b0, "R6 active after wake");
    drive(1, 1'b1, 1'b0, 4'h5, 1'b1, D, 1'b0, "R6 data after wake");

    // R6 drop in sleep; R8 request during wake ignored
    req(1, 1'b1, I, 1'b0, "R3 request cycle 2");
    req(3, 1'b1, P, 1'b1, "R3 sleep 2");
    idle(1, 1'b1, P, 1'b1, "R6 drop in sleep");
    req(WK, 1'b1, I, 1'b0, "R8 wake ignores request");
    req(1, 1'b1, I, 1'b0, "R8 active after full wake");
    req(SL, 1'b1, P, 1'b1, "R3 sleep 3");
    req(QT, 1'b1, S, 1'b1, "R4 quiet 3");
    req(2, 1'b1, P, 1'b1, "R5 refresh part");
    idle(1, 1'b1, P, 1'b1, "R6 drop in refresh");
    idle(WK, 1'b1, I, 1'b0, "R6 wake from refresh");
    idle(1, 1'b1, I, 1'b0, "R6 active after refresh wake");

    // R7 link loss; R8 request ignored without link
    req(1, 1'b1, I, 1'b0, "R3 request cycle 4");
    req(SL, 1'b1, P, 1'b1, "R3 sleep 4");
    req(4, 1'b1, S, 1'b1, "R4 quiet 4");
    req(1, 1'b0, S, 1'b1, "R7 link drop cycle");
    req(3, 1'b0, I, 1'b0, "R8 request without link");
    drive(1, 1'b1, 1'b0, 4'h3, 1'b0, D, 1'b0, "R7 data without link");
    req(1, 1'b1, I, 1'b0, "R7 request after link");
    req(SL, 1'b1, P, 1'b1, "R7 full sleep after link loss");
    req(1, 1'b1, S, 1'b1, "R7 quiet after fresh sleep");
    idle(1, 1'b0, S, 1'b1, "R7 link drop 2");
    idle(2, 1'b1, I, 1'b0, "R7 active after link drop");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    #3;
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule